// File: doc/BRIEF.md
# Early-Update Register Scoreboard

This block keeps one ready bit for each architectural register in a cluster's register file. When an operation issues, the issue logic marks its destination as pending. The producer later marks the register ready again through an update port. It does this two cycles before write-back, not at write-back. A dependent operation can then pass the scoreboard-check stage early enough to take its operand from the bypass path instead of waiting for the register file. A memory load response also marks its destination ready, in the cycle its data is written into the register file.

The check ports sit in a dedicated stage ahead of register read and use no register-file read ports. Each check port takes the source register indices of one candidate operation and a mask that says which of those sources are present. It returns one flag that is high only when every present source is ready. The issue logic forwards only flagged operations to register read. Another thread's operation can take the slot of a blocked one, so the pipeline does not stall with a bubble. There is one check port per register-file read port and one update port per register-file write port.

Top module: `reg_scoreboard`

## Requirements
- R1: Right after reset every register reads as ready. A later reset restores all registers to ready, whatever their state was before it.
- R2: An issue-port request with valid high and destination d (d not 0) makes register d read as not ready from the next cycle onward. Other registers are not affected.
- R3: An update-port request with valid high and destination d makes register d read as ready from the next cycle. In the cycle the request is driven, the check ports still report the old state.
- R4: A memory response with valid high and destination d makes register d read as ready from the next cycle.
- R5: If a set (update port or memory response) and an issue clear target the same register in the same cycle, the register is ready afterwards.
- R6: Register 0 always reads as ready. An issue clear aimed at register 0 has no effect.
- R7: A check port's ready flag is high exactly when every source whose mask bit is 1 indexes a ready register. Sources whose mask bit is 0 are ignored, and a port with an all-zero mask reports ready.
- R8: All check ports are evaluated independently in the same cycle. Each one reports on its own sources only.
- R9: All issue ports and all update ports act in the same cycle, each on its own destination, without interfering with one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chk_src_i | input | NUM_CHK*NUM_SRC*IDX_W | Source indices; port p, source s at bits [(p*NUM_SRC+s)*IDX_W +: IDX_W] |
| chk_used_i | input | NUM_CHK*NUM_SRC | Source-present mask; bit p*NUM_SRC+s |
| chk_ready_o | output | NUM_CHK | All present sources of port p are ready |
| iss_valid_i | input | NUM_ISS | Issue clear request per issue port |
| iss_dst_i | input | NUM_ISS*IDX_W | Destination to mark pending, per issue port |
| upd_valid_i | input | NUM_UPD | Early ready-set request per update port |
| upd_dst_i | input | NUM_UPD*IDX_W | Destination to mark ready, per update port |
| mem_valid_i | input | 1 | Memory load response valid |
| mem_dst_i | input | IDX_W | Destination register of the load response |

## Verification
The bench builds the block with 16 registers, three check ports of three sources each, two issue ports and two update ports. With a small register file, a full sweep of every register can run after reset and again after a mid-run reset. Three check ports let one cycle show ready, blocked and masked-source results side by side. Two issue and two update ports bring concurrent clears and sets, and set-versus-clear collisions on one register from both the update port and the memory response, within reach.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [1:0] {
    SB_HOLD  = 2'd0,
    SB_CLEAR = 2'd1,
    SB_SET   = 2'd2
  } sb_op_e;
endpackage

// File: rtl/sb_state.sv
module sb_state
  import sb_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int IDX_W    = 5,
  parameter int NUM_SET  = 3,
  parameter int NUM_CLR  = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_SET-1:0]         set_valid_i,
  input  logic [NUM_SET*IDX_W-1:0]   set_idx_i,
  input  logic [NUM_CLR-1:0]         clr_valid_i,
  input  logic [NUM_CLR*IDX_W-1:0]   clr_idx_i,
  output logic [NUM_REGS-1:0]        ready_o
);
  assign ready_o[0] = 1'b1;  // register 0 is hardwired ready

  for (genvar r = 1; r < NUM_REGS; r++) begin : g_reg
    sb_op_e op;
    logic   rdy_q;

    always_comb begin
      logic set_hit, clr_hit;
      set_hit = 1'b0;
      clr_hit = 1'b0;
      for (int k = 0; k < NUM_SET; k++)
        if (set_valid_i[k] && set_idx_i[k*IDX_W +: IDX_W] == IDX_W'(r)) set_hit = 1'b1;
      for (int k = 0; k < NUM_CLR; k++)
        if (clr_valid_i[k] && clr_idx_i[k*IDX_W +: IDX_W] == IDX_W'(r)) clr_hit = 1'b1;
      // set wins over clear
      if (set_hit)      op = SB_SET;
      else if (clr_hit) op = SB_CLEAR;
      else              op = SB_HOLD;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rdy_q <= 1'b1;
      else begin
        case (op)
          SB_SET:   rdy_q <= 1'b1;
          SB_CLEAR: rdy_q <= 1'b0;
          default:  rdy_q <= rdy_q;
        endcase
      end
    end

    assign ready_o[r] = rdy_q;
  end
endmodule

// File: rtl/sb_check.sv
module sb_check #(
  parameter int NUM_REGS = 32,
  parameter int IDX_W    = 5,
  parameter int NUM_SRC  = 3
) (
  input  logic [NUM_REGS-1:0]      ready_i,
  input  logic [NUM_SRC*IDX_W-1:0] src_i,
  input  logic [NUM_SRC-1:0]       used_i,
  output logic                     ready_o
);
  logic [NUM_SRC-1:0] src_ok;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    assign src_ok[s] = !used_i[s] || ready_i[src_i[s*IDX_W +: IDX_W]];
  end

  assign ready_o = &src_ok;
endmodule

// File: rtl/reg_scoreboard.sv
module reg_scoreboard #(
  parameter int NUM_REGS = 32,
  parameter int NUM_CHK  = 2,
  parameter int NUM_SRC  = 3,
  parameter int NUM_ISS  = 2,
  parameter int NUM_UPD  = 2,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int NUM_SET = NUM_UPD + 1
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_CHK*NUM_SRC*IDX_W-1:0] chk_src_i,
  input  logic [NUM_CHK*NUM_SRC-1:0]       chk_used_i,
  output logic [NUM_CHK-1:0]               chk_ready_o,
  input  logic [NUM_ISS-1:0]               iss_valid_i,
  input  logic [NUM_ISS*IDX_W-1:0]         iss_dst_i,
  input  logic [NUM_UPD-1:0]               upd_valid_i,
  input  logic [NUM_UPD*IDX_W-1:0]         upd_dst_i,
  input  logic                             mem_valid_i,
  input  logic [IDX_W-1:0]                 mem_dst_i
);
  logic [NUM_REGS-1:0]      ready_q;
  logic [NUM_SET-1:0]       set_valid;
  logic [NUM_SET*IDX_W-1:0] set_idx;

  // memory response rides as the top set lane
  assign set_valid = {mem_valid_i, upd_valid_i};
  assign set_idx   = {mem_dst_i, upd_dst_i};

  sb_state #(
    .NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .NUM_SET(NUM_SET), .NUM_CLR(NUM_ISS)
  ) i_state (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_valid_i (set_valid),
    .set_idx_i   (set_idx),
    .clr_valid_i (iss_valid_i),
    .clr_idx_i   (iss_dst_i),
    .ready_o     (ready_q)
  );

  for (genvar p = 0; p < NUM_CHK; p++) begin : g_chk
    sb_check #(
      .NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .NUM_SRC(NUM_SRC)
    ) i_check (
      .ready_i (ready_q),
      .src_i   (chk_src_i[p*NUM_SRC*IDX_W +: NUM_SRC*IDX_W]),
      .used_i  (chk_used_i[p*NUM_SRC +: NUM_SRC]),
      .ready_o (chk_ready_o[p])
    );
  end
endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
  parameter int NUM_REGS = 32,
  parameter int NUM_CHK  = 2,
  parameter int NUM_SRC  = 3,
  parameter int NUM_ISS  = 2,
  parameter int NUM_UPD  = 2,
  parameter int IDX_W    = 5
) (
  input logic                             clk_i,
  input logic                             rst_ni,
  input logic [NUM_CHK*NUM_SRC*IDX_W-1:0] chk_src_i,
  input logic [NUM_CHK*NUM_SRC-1:0]       chk_used_i,
  input logic [NUM_CHK-1:0]               chk_ready_o,
  input logic [NUM_ISS-1:0]               iss_valid_i,
  input logic [NUM_ISS*IDX_W-1:0]         iss_dst_i,
  input logic [NUM_UPD-1:0]               upd_valid_i,
  input logic [NUM_UPD*IDX_W-1:0]         upd_dst_i,
  input logic                             mem_valid_i,
  input logic [IDX_W-1:0]                 mem_dst_i,
  input logic [NUM_REGS-1:0]              ready_q
);
  logic [NUM_ISS-1:0] iss_collide;

  always_comb begin
    for (int j = 0; j < NUM_ISS; j++) begin
      iss_collide[j] = mem_valid_i && mem_dst_i == iss_dst_i[j*IDX_W +: IDX_W];
      for (int k = 0; k < NUM_UPD; k++)
        if (upd_valid_i[k] && upd_dst_i[k*IDX_W +: IDX_W] == iss_dst_i[j*IDX_W +: IDX_W])
          iss_collide[j] = 1'b1;
    end
  end

  AST_REG0_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_q[0]); // R6

  AST_MEM_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_i |=> ready_q[$past(mem_dst_i)]); // R4

  for (genvar k = 0; k < NUM_UPD; k++) begin : g_upd
    AST_UPD_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      upd_valid_i[k] |=> ready_q[$past(upd_dst_i[k*IDX_W +: IDX_W])]); // R3
  end

  for (genvar j = 0; j < NUM_ISS; j++) begin : g_iss
    AST_ISS_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      iss_valid_i[j] && iss_dst_i[j*IDX_W +: IDX_W] != '0 && !iss_collide[j]
      |=> !ready_q[$past(iss_dst_i[j*IDX_W +: IDX_W])]); // R2
  end

  for (genvar p = 0; p < NUM_CHK; p++) begin : g_chk
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      AST_CHK_SOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        chk_ready_o[p] && chk_used_i[p*NUM_SRC+s]
        |-> ready_q[chk_src_i[(p*NUM_SRC+s)*IDX_W +: IDX_W]]); // R7
    end
  end
endmodule

bind reg_scoreboard sb_checker #(
  .NUM_REGS(NUM_REGS), .NUM_CHK(NUM_CHK), .NUM_SRC(NUM_SRC),
  .NUM_ISS(NUM_ISS), .NUM_UPD(NUM_UPD), .IDX_W(IDX_W)
) i_sb_checker (.*);

// File: tb/test_reg_scoreboard.sv
module test_reg_scoreboard;
  localparam int NR = 16, IW = 4, NC = 3, NS = 3, NI = 2, NU = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NC*NS*IW-1:0] chk_src;
  logic [NC*NS-1:0]    chk_used;
  logic [NC-1:0]       chk_ready;
  logic [NI-1:0]       iss_valid;
  logic [NI*IW-1:0]    iss_dst;
  logic [NU-1:0]       upd_valid;
  logic [NU*IW-1:0]    upd_dst;
  logic                mem_valid;
  logic [IW-1:0]       mem_dst;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  reg_scoreboard #(.NUM_REGS(NR), .NUM_CHK(NC), .NUM_SRC(NS), .NUM_ISS(NI), .NUM_UPD(NU))
  i_reg_scoreboard (
    .clk_i(clk), .rst_ni(rst_n), .chk_src_i(chk_src), .chk_used_i(chk_used),
    .chk_ready_o(chk_ready), .iss_valid_i(iss_valid), .iss_dst_i(iss_dst),
    .upd_valid_i(upd_valid), .upd_dst_i(upd_dst), .mem_valid_i(mem_valid),
    .mem_dst_i(mem_dst)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic idle();
    chk_src = '0; chk_used = '0; iss_valid = '0; iss_dst = '0;
    upd_valid = '0; upd_dst = '0; mem_valid = 1'b0; mem_dst = '0;
  endtask

  // let one edge pass, then drop requests
  task automatic step();
    @(posedge clk); #1; idle();
  endtask

  task automatic probe(input int r, output logic rdy);
    chk_src[IW-1:0] = IW'(r); chk_used = 'b1; #0.5;
    rdy = chk_ready[0];
    chk_used = '0; chk_src = '0; #0.5;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; @(posedge clk); @(posedge clk); #1; rst_n = 1'b1; #1;
  endtask

  task automatic t_reset();
    logic rdy;
    bit all = 1'b1;
    for (int r = 0; r < NR; r++) begin probe(r, rdy); if (rdy !== 1'b1) all = 1'b0; end
    check("R1 all ready after reset", all, 1'b1);
    iss_valid = 2'b11; iss_dst = {4'd2, 4'd3}; step();
    probe(3, rdy); check("R2 pre-reset clear", rdy, 1'b0);
    do_reset();
    probe(3, rdy); check("R1 reg3 ready after re-reset", rdy, 1'b1);
    probe(2, rdy); check("R1 reg2 ready after re-reset", rdy, 1'b1);
  endtask

  task automatic t_issue_update();
    logic rdy;
    iss_valid[0] = 1'b1; iss_dst[IW-1:0] = 4'd5; step();
    probe(5, rdy); check("R2 reg5 pending", rdy, 1'b0);
    probe(6, rdy); check("R2 reg6 untouched", rdy, 1'b1);
    upd_valid[1] = 1'b1; upd_dst[IW +: IW] = 4'd5;
    probe(5, rdy); check("R3 old state in update cycle", rdy, 1'b0);
    step();
    probe(5, rdy); check("R3 reg5 ready after update", rdy, 1'b1);
  endtask

  task automatic t_mem();
    logic rdy;
    iss_valid[1] = 1'b1; iss_dst[IW +: IW] = 4'd7; step();
    probe(7, rdy); check("R2 reg7 pending", rdy, 1'b0);
    mem_valid = 1'b1; mem_dst = 4'd7; step();
    probe(7, rdy); check("R4 reg7 ready after load", rdy, 1'b1);
  endtask

  task automatic t_conflict();
    logic rdy;
    iss_valid[0] = 1'b1; iss_dst[IW-1:0] = 4'd9;
    upd_valid[0] = 1'b1; upd_dst[IW-1:0] = 4'd9; step();
    probe(9, rdy); check("R5 update beats clear", rdy, 1'b1);
    iss_valid[1] = 1'b1; iss_dst[IW +: IW] = 4'd8;
    mem_valid = 1'b1; mem_dst = 4'd8; step();
    probe(8, rdy); check("R5 load beats clear", rdy, 1'b1);
  endtask

  task automatic t_reg0();
    logic rdy;
    iss_valid = 2'b01; iss_dst = '0; step();
    probe(0, rdy); check("R6 reg0 stays ready", rdy, 1'b1);
  endtask

  task automatic t_sources();
    iss_valid[0] = 1'b1; iss_dst[IW-1:0] = 4'd3; step();
    // port1 sources {3,4,0}
    chk_src[NS*IW +: NS*IW] = {4'd0, 4'd4, 4'd3};
    chk_used[NS +: NS] = 3'b111; #1;
    check("R7 pending source blocks", chk_ready[1], 1'b0);
    chk_used[NS +: NS] = 3'b110; #1;
    check("R7 masked source ignored", chk_ready[1], 1'b1);
    chk_used[NS +: NS] = 3'b000; #1;
    check("R7 empty mask ready", chk_ready[1], 1'b1);
    idle();
  endtask

  task automatic t_ports();
    // reg3 still pending from t_sources
    chk_src = {4'd0, 4'd3, 4'd2, 4'd0, 4'd1, 4'd6, 4'd4, 4'd3, 4'd1};
    chk_used = 9'b010_011_011; #1;
    check("R8 port0 blocked", chk_ready[0], 1'b0);
    check("R8 port1 ready", chk_ready[1], 1'b1);
    check("R8 port2 blocked", chk_ready[2], 1'b0);
    idle();
  endtask

  task automatic t_parallel();
    logic rdy;
    iss_valid = 2'b11; iss_dst = {4'd11, 4'd10}; step();
    probe(10, rdy); check("R9 dual clear reg10", rdy, 1'b0);
    probe(11, rdy); check("R9 dual clear reg11", rdy, 1'b0);
    upd_valid = 2'b11; upd_dst = {4'd10, 4'd11};
    iss_valid = 2'b11; iss_dst = {4'd13, 4'd12}; step();
    probe(10, rdy); check("R9 dual set reg10", rdy, 1'b1);
    probe(11, rdy); check("R9 dual set reg11", rdy, 1'b1);
    probe(12, rdy); check("R9 concurrent clear reg12", rdy, 1'b0);
    probe(13, rdy); check("R9 concurrent clear reg13", rdy, 1'b0);
  endtask

  initial begin
    idle();
    do_reset();
    t_reset();
    t_issue_update();
    t_mem();
    t_conflict();
    t_reg0();
    t_sources();
    t_ports();
    t_parallel();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule